// File: doc/BRIEF.md
# Mode-Banked Integer Register File

This block is the integer register file of a 32-bit processor core that runs in several privilege modes. Software addresses sixteen architectural registers by a 4-bit index. The file turns each index into a physical storage slot, using the current mode. The low eight registers are common to every mode. The middle five have a private set for the fast-interrupt mode. The stack and link registers have per-mode copies, and a few modes share the user copy. There are two combinational read ports and one write port. All three ports use the same mode input.

Index 15 is the program counter, and it is not stored in the file. A read of index 15 returns the current instruction address from the `pcIn` port. A per-port flag can ask for that address with its two low bits cleared. A write to index 15 is turned into a branch request that carries a target address and an instruction-set state bit.

Mode codes (4 bits): 0 user, 1 fast-interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 hypervisor, 7 system. Codes 8 to 15 are not defined.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 select the same physical register in every mode. A value written in one mode reads back unchanged in any other mode.
- R2: Indices 8 to 12 use a private set in fast-interrupt mode (code 1). Every other defined mode uses one shared user set.
- R3: Index 13 has a private copy in each of fast-interrupt, interrupt, supervisor, abort, undefined and hypervisor modes. User (0) and system (7) share one copy.
- R4: Index 14 has a private copy in each of fast-interrupt, interrupt, supervisor, abort and undefined modes. User, system and hypervisor (6) share the user copy.
- R5: A read of index 15 returns `pcIn` when the port's align flag is 0. When the flag is 1, it returns `pcIn` with bits 1:0 cleared. The align flag has no effect on any other index.
- R6: A write to indices 0 to 14 takes effect at the rising clock edge. A read of the same register in the write cycle returns the old value, and reads return the new value from the next cycle on.
- R7: A write to index 15 stores nothing. In the cycle after the write edge, `brValid` is high for exactly one cycle and `isaState` equals bit 0 of the written value. `brTarget` is the written value with bit 0 cleared when that bit is 1, and with bits 1:0 cleared when it is 0. `isaState` holds its value until the next write to index 15.
- R8: When `mode` holds an undefined code (8 to 15), `modeErr` is high in that cycle. A write in that cycle changes no register and raises no branch request.
- R9: A synchronous reset clears every physical register to zero, deasserts `brValid` and clears `isaState`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Current privilege mode code |
| pcIn | input | 32 | Current instruction address |
| rdIdxA | input | 4 | Read port A index |
| rdAlignA | input | 1 | Port A: clear bits 1:0 on an index-15 read |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 4 | Read port B index |
| rdAlignB | input | 1 | Port B: clear bits 1:0 on an index-15 read |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Write index |
| wrData | input | 32 | Write data |
| modeErr | output | 1 | Mode code is undefined |
| brValid | output | 1 | One-cycle branch request |
| brTarget | output | 32 | Branch target address |
| isaState | output | 1 | Instruction-set state flag |

## Verification
The bench writes a distinct value to the stack and link registers from every mode, then reads each one back from every mode. This catches a map that merges hypervisor with user for the stack pointer, or gives hypervisor its own link register. It reads and writes the same register in one cycle to catch a file that forwards the new value, and it reads index 15 with and without alignment. A branch test uses one odd and one even value to expose target masking that ignores the state bit. It also catches a request that stays high for more than one cycle. Writes under an undefined mode code must leave the registers and the branch request untouched, which catches a write path that skips the mode check.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int IDX_W   = 4;
  localparam int MODE_W  = 4;
  localparam int NUM_PHYS = 31;
  localparam int PHYS_W  = $clog2(NUM_PHYS);
  localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

  typedef enum logic [MODE_W-1:0] {
    MODE_USER   = 4'd0,
    MODE_FAST   = 4'd1,
    MODE_IRQ    = 4'd2,
    MODE_SVC    = 4'd3,
    MODE_ABORT  = 4'd4,
    MODE_UNDEF  = 4'd5,
    MODE_HYP    = 4'd6,
    MODE_SYSTEM = 4'd7
  } modeT;

  // Physical layout: 0-7 common, 8-12 user high, 13-17 fast high,
  // 18-24 stack copies, 25-30 link copies.
  localparam int HIGH_USR_BASE = 8;
  localparam int HIGH_FAST_BASE = 13;
  localparam int SP_BASE = 18;
  localparam int LR_BASE = 25;

  typedef struct packed {
    logic              wrReg;
    logic [PHYS_W-1:0] wrPhys;
    logic              takeBranch;
  } ctrlStrobesT;
endpackage

// File: rtl/bank_map.sv
module bank_map
  import regfile_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    phys = '0;
    if (idx < 4'd8) begin
      phys = PHYS_W'(idx);
    end else if (idx <= 4'd12) begin
      if (mode == MODE_FAST) phys = PHYS_W'(HIGH_FAST_BASE) + PHYS_W'(idx - 4'd8);
      else                   phys = PHYS_W'(HIGH_USR_BASE) + PHYS_W'(idx - 4'd8);
    end else if (idx == 4'd13) begin
      case (mode)
        MODE_FAST:  phys = PHYS_W'(SP_BASE + 1);
        MODE_IRQ:   phys = PHYS_W'(SP_BASE + 2);
        MODE_SVC:   phys = PHYS_W'(SP_BASE + 3);
        MODE_ABORT: phys = PHYS_W'(SP_BASE + 4);
        MODE_UNDEF: phys = PHYS_W'(SP_BASE + 5);
        MODE_HYP:   phys = PHYS_W'(SP_BASE + 6);
        default:    phys = PHYS_W'(SP_BASE);
      endcase
    end else if (idx == 4'd14) begin
      case (mode)
        MODE_FAST:  phys = PHYS_W'(LR_BASE + 1);
        MODE_IRQ:   phys = PHYS_W'(LR_BASE + 2);
        MODE_SVC:   phys = PHYS_W'(LR_BASE + 3);
        MODE_ABORT: phys = PHYS_W'(LR_BASE + 4);
        MODE_UNDEF: phys = PHYS_W'(LR_BASE + 5);
        default:    phys = PHYS_W'(LR_BASE);
      endcase
    end
  end
endmodule

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PHYS_W-1:0] wrPhys,
  output ctrlStrobesT       strobes,
  output logic              modeErr
);
  logic modeOk;

  always_comb begin
    modeOk             = (mode <= MODE_W'(MODE_SYSTEM));
    modeErr            = !modeOk;
    strobes.wrReg      = wrEn && modeOk && (wrIdx != PC_IDX);
    strobes.takeBranch = wrEn && modeOk && (wrIdx == PC_IDX);
    strobes.wrPhys     = wrPhys;
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctrlStrobesT                    strobes,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [DATA_W-1:0]              pcIn,
  input  logic [NUM_RD-1:0][PHYS_W-1:0]  rdPhys,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   rdIdx,
  input  logic [NUM_RD-1:0]              rdAlign,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData,
  output logic                           brValid,
  output logic [DATA_W-1:0]              brTarget,
  output logic                           isaState
);
  logic [DATA_W-1:0] regs [NUM_PHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++) regs[i] <= '0;
    end else if (strobes.wrReg) begin
      regs[strobes.wrPhys] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brValid  <= 1'b0;
      brTarget <= '0;
      isaState <= 1'b0;
    end else begin
      brValid <= strobes.takeBranch;
      if (strobes.takeBranch) begin
        isaState <= wrData[0];
        if (wrData[0]) brTarget <= {wrData[DATA_W-1:1], 1'b0};
        else           brTarget <= {wrData[DATA_W-1:2], 2'b00};
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (rdIdx[p] == PC_IDX) begin
        if (rdAlign[p]) rdData[p] = {pcIn[DATA_W-1:2], 2'b00};
        else            rdData[p] = pcIn;
      end else begin
        rdData[p] = regs[rdPhys[p]];
      end
    end

    assert_aligned_pc_R5: assert property (@(posedge clk) disable iff (rst)
      (rdIdx[p] == PC_IDX && rdAlign[p]) |-> (rdData[p][1:0] == 2'b00 &&
        rdData[p][DATA_W-1:2] == pcIn[DATA_W-1:2]));
  end

  assert_target_mask_R7: assert property (@(posedge clk) disable iff (rst)
    brValid |-> (isaState ? (brTarget[0] == 1'b0) : (brTarget[1:0] == 2'b00)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [3:0]        rdIdxA,
  input  logic              rdAlignA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  input  logic              rdAlignB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              modeErr,
  output logic              brValid,
  output logic [DATA_W-1:0] brTarget,
  output logic              isaState
);
  localparam int NUM_RD = 2;
  localparam int NUM_MAP = NUM_RD + 1;

  logic [NUM_MAP-1:0][IDX_W-1:0]  mapIdx;
  logic [NUM_MAP-1:0][PHYS_W-1:0] mapPhys;
  logic [NUM_RD-1:0][DATA_W-1:0]  rdData;
  ctrlStrobesT strobes;

  assign mapIdx = {wrIdx, rdIdxB, rdIdxA};

  for (genvar p = 0; p < NUM_MAP; p++) begin : g_map
    bank_map uMap (.mode(mode), .idx(mapIdx[p]), .phys(mapPhys[p]));
  end

  regfile_ctrl uCtrl (
    .mode(mode), .wrEn(wrEn), .wrIdx(wrIdx), .wrPhys(mapPhys[NUM_RD]),
    .strobes(strobes), .modeErr(modeErr)
  );

  regfile_dp #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData), .pcIn(pcIn),
    .rdPhys(mapPhys[NUM_RD-1:0]), .rdIdx({rdIdxB, rdIdxA}),
    .rdAlign({rdAlignB, rdAlignA}), .rdData(rdData),
    .brValid(brValid), .brTarget(brTarget), .isaState(isaState)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  assert_err_no_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (modeErr && wrEn) |=> !brValid);

  assert_branch_cause_R7: assert property (@(posedge clk) disable iff (rst)
    brValid |-> $past(wrEn && wrIdx == 4'd15 && mode <= 4'd7));

  assert_err_range_R8: assert property (@(posedge clk) disable iff (rst)
    modeErr == mode[3]);
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode = '0;
  logic [31:0] pcIn = '0;
  logic [3:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic        rdAlignA = 1'b0, rdAlignB = 1'b0, wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB, brTarget;
  logic        modeErr, brValid, isaState;

  int total = 0;
  int bad = 0;
  bit done = 0;

  banked_regfile dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] m, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    mode = m; wrIdx = idx; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdA(input logic [3:0] m, input logic [3:0] idx, input logic al,
                     output logic [31:0] d);
    @(negedge clk);
    mode = m; rdIdxA = idx; rdAlignA = al;
    #1 d = rdDataA;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R9 brValid", {31'b0, brValid}, 32'd0);
    check("R9 isaState", {31'b0, isaState}, 32'd0);
    rdA(4'd0, 4'd3, 1'b0, d);  check("R9 r3", d, 0);
    rdA(4'd1, 4'd13, 1'b0, d); check("R9 fast sp", d, 0);
    rdA(4'd3, 4'd14, 1'b0, d); check("R9 svc lr", d, 0);
  endtask

  task automatic t_low;
    logic [31:0] d;
    wr(4'd2, 4'd3, 32'hA5A5_0003);
    for (int m = 0; m < 8; m++) begin
      rdA(4'(m), 4'd3, 1'b0, d); check("R1 shared r3", d, 32'hA5A5_0003);
    end
  endtask

  task automatic t_high;
    logic [31:0] d;
    wr(4'd0, 4'd10, 32'h0000_1010);
    wr(4'd1, 4'd10, 32'h0000_F010);
    rdA(4'd0, 4'd10, 1'b0, d); check("R2 user r10", d, 32'h1010);
    rdA(4'd3, 4'd10, 1'b0, d); check("R2 svc r10", d, 32'h1010);
    rdA(4'd7, 4'd10, 1'b0, d); check("R2 system r10", d, 32'h1010);
    rdA(4'd1, 4'd10, 1'b0, d); check("R2 fast r10", d, 32'hF010);
  endtask

  task automatic t_sp;
    logic [31:0] d;
    logic [31:0] exp;
    for (int m = 0; m < 8; m++) wr(4'(m), 4'd13, 32'h5000 + 32'(m));
    for (int m = 0; m < 8; m++) begin
      exp = (m == 0) ? 32'h5007 : 32'h5000 + 32'(m);
      rdA(4'(m), 4'd13, 1'b0, d); check("R3 stack copy", d, exp);
    end
  endtask

  task automatic t_lr;
    logic [31:0] d;
    logic [31:0] exp;
    for (int m = 0; m < 8; m++) wr(4'(m), 4'd14, 32'h7000 + 32'(m));
    for (int m = 0; m < 8; m++) begin
      exp = (m == 0 || m == 6 || m == 7) ? 32'h7007 : 32'h7000 + 32'(m);
      rdA(4'(m), 4'd14, 1'b0, d); check("R4 link copy", d, exp);
    end
  endtask

  task automatic t_pc;
    logic [31:0] d;
    @(negedge clk);
    pcIn = 32'h0000_1003;
    rdA(4'd0, 4'd15, 1'b0, d); check("R5 raw pc", d, 32'h1003);
    rdA(4'd0, 4'd15, 1'b1, d); check("R5 aligned pc A", d, 32'h1000);
    @(negedge clk);
    rdIdxB = 4'd15; rdAlignB = 1'b1;
    #1 check("R5 aligned pc B", rdDataB, 32'h1000);
    wr(4'd0, 4'd4, 32'h0000_0007);
    rdA(4'd0, 4'd4, 1'b1, d); check("R5 align ignored r4", d, 32'h7);
  endtask

  task automatic t_same;
    @(negedge clk);
    mode = 4'd0; rdIdxA = 4'd5; rdAlignA = 1'b0;
    wrIdx = 4'd5; wrData = 32'h1111_0005; wrEn = 1'b1;
    #1 check("R6 old value in write cycle", rdDataA, 32'd0);
    @(posedge clk); #1;
    wrEn = 1'b0;
    check("R6 new value after edge", rdDataA, 32'h1111_0005);
  endtask

  task automatic t_branch;
    logic [31:0] d;
    wr(4'd3, 4'd15, 32'h0000_2003);
    check("R7 brValid", {31'b0, brValid}, 32'd1);
    check("R7 target odd", brTarget, 32'h2002);
    check("R7 isa odd", {31'b0, isaState}, 32'd1);
    @(posedge clk); #1;
    check("R7 pulse one cycle", {31'b0, brValid}, 32'd0);
    check("R7 isa holds", {31'b0, isaState}, 32'd1);
    wr(4'd0, 4'd15, 32'h0000_3006);
    check("R7 target even", brTarget, 32'h3004);
    check("R7 isa even", {31'b0, isaState}, 32'd0);
    rdA(4'd0, 4'd15, 1'b0, d); check("R7 pc not stored", d, 32'h1003);
  endtask

  task automatic t_bad;
    logic [31:0] d;
    @(negedge clk);
    mode = 4'd9;
    #1 check("R8 modeErr", {31'b0, modeErr}, 32'd1);
    wr(4'd9, 4'd2, 32'hDEAD_0002);
    check("R8 no branch on reg write", {31'b0, brValid}, 32'd0);
    wr(4'd12, 4'd15, 32'h0000_4001);
    check("R8 no branch", {31'b0, brValid}, 32'd0);
    rdA(4'd0, 4'd2, 1'b0, d); check("R8 r2 unchanged", d, 32'd0);
    #1 check("R8 modeErr clear", {31'b0, modeErr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_low();
    t_high();
    t_sp();
    t_lr();
    t_pc();
    t_same();
    t_branch();
    t_bad();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule